// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block drives the command line of an SD or MMC card for one command at a time and, when asked, collects the card's reply. Software first loads a 32-bit argument register. It then writes the command register with an opcode and control bits. The engine builds a 48-bit frame, adds a CRC7 it computes itself, and shifts the frame out one bit per clock with the most significant bit first. It then either finishes at once or listens for a 48-bit or 136-bit response within a bounded window. The outcome is recorded in one of four sticky status flags.

The controller has five states. `S_IDLE` waits for a command write with the enable bit set (transition *start*). `S_SEND` drives the 48 frame bits. After the end bit it moves to `S_WAIT` if a response is expected (*to_wait*) and to `S_GAP` if not (*no_resp_done*). `S_WAIT` watches the line for a start bit (*start_seen*, to `S_RECV`) or gives up after the window (*timeout*, to `S_GAP`). `S_RECV` shifts in the rest of the response (*rx_done*, to `S_GAP`). `S_GAP` holds the engine busy for the turnaround period (*gap_done*, to `S_IDLE`). From any state, a command write with the enable bit clear (*abort*) returns the engine to `S_IDLE`.

Command register fields: bits [5:0] hold the index. Bit 6 means a response is expected. Bit 7 selects the 136-bit response. Bit 8 turns off the response CRC check. Bit 9 is the enable bit. Status bits: [0] sent with no response, [1] response good, [2] response CRC error, [3] response timeout.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset, `busy`, `cmd_oe` and all status bits are 0, `cmd_out` is 1 and all four response words are 0.
- R2: A started command appears on `cmd_out`, with `cmd_oe` high, for exactly 48 consecutive cycles, beginning in the cycle after the write. The bits, MSB first, are 0, 1, the 6-bit index, the 32-bit argument, the CRC7 (polynomial x^7+x^3+1, zero seed) of the first 40 bits, and 1. Outside a frame `cmd_out` is 1.
- R3: A command write with bit 9 set starts a command only from `S_IDLE`. While `busy` is high, including the gap, such a write is ignored.
- R4: A command write with bit 9 clear sends the engine to idle by the next cycle. The interrupted command raises no status flag.
- R5: With bit 6 clear, status bit 0 is set at the edge that ends the end bit.
- R6: With bit 6 set, the line is sampled on each of the 64 clocks after the end bit. If no 0 is seen, status bit 3 is set on the 64th of those clocks.
- R7: A short response is 48 bits starting with a 0 on the line. Its bits [39:8] go to `resp0`, and `resp1`..`resp3` become 0. Status bit 1 is set when the CRC7 of bits [47:8] equals bits [7:1]; otherwise status bit 2 is set.
- R8: With bit 8 set, a short response sets status bit 1 whatever its CRC field holds.
- R9: With bit 7 set, a 136-bit response is captured: frame bits [127:96], [95:64], [63:32] and [31:0] go to `resp0`..`resp3`. Status bit 1 is set and no CRC is checked.
- R10: Every completion is followed by 8 cycles with `busy` high before the engine accepts a new command.
- R11: Status bits are sticky. Writing 1 to a bit of the clear register clears that bit and leaves the others. A flag that is set in the same cycle wins over its clear.
- R12: One completion raises exactly one status flag, and no flag is raised while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_wr | input | 1 | Write strobe for the argument register |
| arg_wdata | input | 32 | Argument value |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 10 | Index [5:0], response [6], long [7], no-CRC [8], enable [9] |
| clr_wr | input | 1 | Write strobe for the status clear register |
| clr_wdata | input | 4 | Write-1-to-clear mask for the status bits |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line value driven by the host |
| cmd_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | Engine is not idle |
| status | output | 4 | Sticky completion flags |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |

## Verification
Two known-answer frames check the serialiser and CRC7 generator against fixed bit patterns: index 0 with a zero argument, and index 8 with a non-trivial argument. Short responses carrying a correct CRC, a corrupted CRC, and a corrupted CRC with checking off separate the three CRC outcomes. A long response with arbitrary content shows that its CRC is ignored and that the four words land in the right order. A silent line separates a timeout from a late start bit, and the reference model pins the exact cycle of the timeout. Command writes in the middle of a frame, with and without the enable bit, separate an ignored write from an abort. A partial clear mask shows that each flag clears on its own.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int ARG_W      = 32;
    localparam int IDX_W      = 6;
    localparam int CMD_W      = 10;
    localparam int BIT_RESP   = 6;
    localparam int BIT_LONG   = 7;
    localparam int BIT_NOCRC  = 8;
    localparam int BIT_EN     = 9;
    localparam int CRC_W      = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int HEAD_BITS  = SHORT_BITS - CRC_W - 1;
    localparam int NUM_FLAGS  = 4;
    localparam int FLAG_SENT  = 0;
    localparam int FLAG_OK    = 1;
    localparam int FLAG_CRC   = 2;
    localparam int FLAG_TOUT  = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_WAIT,
        S_RECV,
        S_GAP
    } sdc_state_e;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 import sdc_pkg::*; #(
    parameter int N = HEAD_BITS
) (
    input  logic [N-1:0]     data,
    output logic [CRC_W-1:0] crc
);
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = N - 1; i >= 0; i--) begin
            fb  = data[i] ^ acc[CRC_W-1];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) acc = acc ^ CRC_POLY;
        end
        crc = acc;
    end
endmodule

// File: rtl/sdc_flags.sv
module sdc_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[g] <= 1'b0;
            else if (set[g]) flags[g] <= 1'b1;
            else if (clr[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine import sdc_pkg::*; #(
    parameter int TIMEOUT_CLKS = 64,
    parameter int GAP_CLKS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arg_wr,
    input  logic [ARG_W-1:0]     arg_wdata,
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_wdata,
    input  logic                 clr_wr,
    input  logic [NUM_FLAGS-1:0] clr_wdata,
    input  logic                 cmd_in,
    output logic                 cmd_out,
    output logic                 cmd_oe,
    output logic                 busy,
    output logic [NUM_FLAGS-1:0] status,
    output logic [31:0]          resp0,
    output logic [31:0]          resp1,
    output logic [31:0]          resp2,
    output logic [31:0]          resp3
);
    localparam int SPAN0 = (LONG_BITS > TIMEOUT_CLKS) ? LONG_BITS : TIMEOUT_CLKS;
    localparam int SPAN  = (SPAN0 > GAP_CLKS) ? SPAN0 : GAP_CLKS;
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] SEND_LAST  = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(TIMEOUT_CLKS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CLKS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_BITS - 2);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_BITS - 2);

    sdc_state_e state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [SHORT_BITS-1:0] frame_q;
    logic [LONG_BITS-1:0]  sr_q, sr_nx;
    logic [ARG_W-1:0]      arg_q;
    logic want_resp_q, long_q, nocrc_q;
    logic start, abort, rx_done;
    logic [CRC_W-1:0] tx_crc, rx_crc;
    logic [HEAD_BITS-1:0] tx_head;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr;

    assign start   = cmd_wr &  cmd_wdata[BIT_EN];
    assign abort   = cmd_wr & ~cmd_wdata[BIT_EN];
    assign sr_nx   = {sr_q[LONG_BITS-2:0], cmd_in};
    assign tx_head = {2'b01, cmd_wdata[IDX_W-1:0], arg_q};
    assign rx_done = (state_q == S_RECV) &&
                     (cnt_q == (long_q ? LONG_LAST : SHORT_LAST));

    sdc_crc7 #(.N(HEAD_BITS)) u_tx_crc (.data(tx_head), .crc(tx_crc));
    sdc_crc7 #(.N(HEAD_BITS)) u_rx_crc (.data(sr_nx[SHORT_BITS-1:CRC_W+1]), .crc(rx_crc));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_SEND;
            S_SEND: if (cnt_q == SEND_LAST) state_d = want_resp_q ? S_WAIT : S_GAP;
            S_WAIT: begin
                if (!cmd_in)                 state_d = S_RECV;
                else if (cnt_q == WAIT_LAST) state_d = S_GAP;
            end
            S_RECV: if (rx_done) state_d = S_GAP;
            S_GAP:  if (cnt_q == GAP_LAST) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            frame_q     <= '1;
            sr_q        <= '1;
            arg_q       <= '0;
            want_resp_q <= 1'b0;
            long_q      <= 1'b0;
            nocrc_q     <= 1'b0;
            resp0       <= '0;
            resp1       <= '0;
            resp2       <= '0;
            resp3       <= '0;
        end else begin
            cnt_q <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (arg_wr) arg_q <= arg_wdata;
            if (state_q == S_IDLE && start) begin
                frame_q     <= {tx_head, tx_crc, 1'b1};
                want_resp_q <= cmd_wdata[BIT_RESP];
                long_q      <= cmd_wdata[BIT_LONG];
                nocrc_q     <= cmd_wdata[BIT_NOCRC];
            end else if (state_q == S_SEND) begin
                frame_q <= {frame_q[SHORT_BITS-2:0], 1'b1};
            end
            if (state_q == S_WAIT || state_q == S_RECV) sr_q <= sr_nx;
            if (rx_done && !abort) begin
                if (long_q) begin
                    resp0 <= sr_nx[127:96];
                    resp1 <= sr_nx[95:64];
                    resp2 <= sr_nx[63:32];
                    resp3 <= sr_nx[31:0];
                end else begin
                    resp0 <= sr_nx[39:8];
                    resp1 <= '0;
                    resp2 <= '0;
                    resp3 <= '0;
                end
            end
        end
    end

    // completion flags
    always_comb begin
        flag_set = '0;
        if (!abort) begin
            flag_set[FLAG_SENT] = (state_q == S_SEND) && (cnt_q == SEND_LAST) && !want_resp_q;
            flag_set[FLAG_TOUT] = (state_q == S_WAIT) && (cnt_q == WAIT_LAST) && cmd_in;
            if (rx_done) begin
                if (long_q || nocrc_q || rx_crc == sr_nx[CRC_W:1]) flag_set[FLAG_OK]  = 1'b1;
                else                                               flag_set[FLAG_CRC] = 1'b1;
            end
        end
        flag_clr = clr_wr ? clr_wdata : '0;
    end

    sdc_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags(status)
    );

    // outputs
    always_comb begin
        busy    = (state_q != S_IDLE);
        cmd_oe  = (state_q == S_SEND);
        cmd_out = cmd_oe ? frame_q[SHORT_BITS-1] : 1'b1;
    end
endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker import sdc_pkg::*; (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_wr,
    input logic [CMD_W-1:0]     cmd_wdata,
    input logic                 cmd_out,
    input logic                 cmd_oe,
    input logic                 busy,
    input logic [NUM_FLAGS-1:0] status
);
    // R2: drive only inside a busy period
    p_oe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> busy);
    // R2: every frame opens with a 0 start bit
    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
    // R2: undriven line idles high
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);
    // R3: busy only rises after an enabled command write
    p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr && cmd_wdata[BIT_EN]));
    // R4: abort reaches idle next cycle
    p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_wdata[BIT_EN]) |=> (!busy && !cmd_oe));
    // R12: never more than one new flag per cycle
    p_one_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status & ~$past(status)) <= 1);
    // R12: new flags only come from a running command
    p_flag_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) != '0) |-> $past(busy));
endmodule

bind sdc_cmd_engine sdc_cmd_checker u_sdc_cmd_checker (.*);

// File: tb/tb_sdc_cmd_engine.sv
module tb_sdc_cmd_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arg_wr = 1'b0, cmd_wr = 1'b0, clr_wr = 1'b0, cmd_in = 1'b1;
    logic [31:0] arg_wdata = '0;
    logic [9:0]  cmd_wdata = '0;
    logic [3:0]  clr_wdata = '0;
    logic cmd_out, cmd_oe, busy;
    logic [3:0] status;
    logic [31:0] resp0, resp1, resp2, resp3;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdc_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy),
        .status(status), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic q[$]);
        logic [6:0] r = '0;
        logic inv;
        for (int i = 0; i < 40; i++) begin
            inv  = q[i] ^ r[6];
            r    = r << 1;
            r[0] = inv;
            r[3] = r[3] ^ inv;
        end
        return r;
    endfunction

    // ---------------- reference model ----------------
    int m_phase = 0;     // 0 idle, 1 send, 2 wait, 3 recv, 4 gap
    int m_cnt = 0;
    logic m_txq[$];
    logic m_rxq[$];
    logic [3:0]  m_stat = '0;
    logic [31:0] m_arg = '0;
    logic [31:0] m_r[4] = '{default: '0};
    bit m_resp, m_long, m_nocrc;

    always @(posedge clk) begin
        logic [3:0] setv;
        setv = '0;
        if (!rst_n) begin
            m_phase = 0; m_stat = '0; m_arg = '0; m_r = '{default: '0};
            m_txq.delete(); m_rxq.delete();
        end else begin
            if (cmd_wr && !cmd_wdata[9]) begin
                m_phase = 0;
            end else begin
                case (m_phase)
                    0: if (cmd_wr && cmd_wdata[9]) begin
                        m_txq.delete();
                        m_txq.push_back(1'b0); m_txq.push_back(1'b1);
                        for (int i = 5; i >= 0; i--) m_txq.push_back(cmd_wdata[i]);
                        for (int i = 31; i >= 0; i--) m_txq.push_back(m_arg[i]);
                        begin
                            logic [6:0] c;
                            c = ref_crc(m_txq);
                            for (int i = 6; i >= 0; i--) m_txq.push_back(c[i]);
                        end
                        m_txq.push_back(1'b1);
                        m_resp = cmd_wdata[6]; m_long = cmd_wdata[7]; m_nocrc = cmd_wdata[8];
                        m_phase = 1;
                    end
                    1: begin
                        void'(m_txq.pop_front());
                        if (m_txq.size() == 0) begin
                            if (m_resp) begin m_phase = 2; m_cnt = 0; end
                            else begin setv[0] = 1; m_phase = 4; m_cnt = 0; end
                        end
                    end
                    2: begin
                        if (!cmd_in) begin
                            m_rxq.delete(); m_rxq.push_back(1'b0); m_phase = 3;
                        end else begin
                            m_cnt++;
                            if (m_cnt == 64) begin setv[3] = 1; m_phase = 4; m_cnt = 0; end
                        end
                    end
                    3: begin
                        m_rxq.push_back(cmd_in);
                        if (m_rxq.size() == (m_long ? 136 : 48)) begin
                            if (m_long) begin
                                for (int w = 0; w < 4; w++)
                                    for (int b = 0; b < 32; b++)
                                        m_r[w][b] = m_rxq[135 - (127 - 32*w - (31 - b))];
                                setv[1] = 1;
                            end else begin
                                logic [6:0] c, got;
                                for (int b = 0; b < 32; b++) m_r[0][b] = m_rxq[39 - b];
                                m_r[1] = '0; m_r[2] = '0; m_r[3] = '0;
                                c = ref_crc(m_rxq);
                                for (int i = 0; i < 7; i++) got[6-i] = m_rxq[40 + i];
                                if (m_nocrc || c == got) setv[1] = 1; else setv[2] = 1;
                            end
                            m_phase = 4; m_cnt = 0;
                        end
                    end
                    4: begin
                        m_cnt++;
                        if (m_cnt == 8) m_phase = 0;
                    end
                    default: m_phase = 0;
                endcase
            end
            m_stat = (m_stat & ~(clr_wr ? clr_wdata : 4'h0)) | setv;
            if (arg_wr) m_arg = arg_wdata;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cmd_oe == (m_phase == 1), "R2 oe", cmd_oe, m_phase == 1);
            chk(cmd_out == ((m_phase == 1) ? m_txq[0] : 1'b1), "R2 line", cmd_out,
                (m_phase == 1) ? m_txq[0] : 1'b1);
            chk(busy == (m_phase != 0), "R10 busy", busy, m_phase != 0);
            chk(status == m_stat, "R11 status", status, m_stat);
            chk({resp0, resp1} == {m_r[0], m_r[1]}, "R7 resp01", {resp0, resp1}, {m_r[0], m_r[1]});
            chk({resp2, resp3} == {m_r[2], m_r[3]}, "R9 resp23", {resp2, resp3}, {m_r[2], m_r[3]});
        end
    end

    // line driver for the card side and capture of the host frame
    logic drv_q[$];
    logic cap[$];
    always @(negedge clk) begin
        if (drv_q.size() > 0) cmd_in <= drv_q.pop_front();
        else                  cmd_in <= 1'b1;
        if (cmd_oe) cap.push_back(cmd_out);
    end

    task automatic wr_arg(input logic [31:0] v);
        @(negedge clk); arg_wr = 1; arg_wdata = v;
        @(negedge clk); arg_wr = 0;
    endtask
    task automatic wr_cmd(input logic [9:0] v);
        @(negedge clk); cmd_wr = 1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 0;
    endtask
    task automatic wr_clr(input logic [3:0] v);
        @(negedge clk); clr_wr = 1; clr_wdata = v;
        @(negedge clk); clr_wr = 0;
    endtask
    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic push_short(input logic [5:0] idx, input logic [31:0] pay, input bit corrupt);
        logic q[$];
        logic [6:0] c;
        q.push_back(1'b0); q.push_back(1'b0);
        for (int i = 5; i >= 0; i--) q.push_back(idx[i]);
        for (int i = 31; i >= 0; i--) q.push_back(pay[i]);
        c = ref_crc(q);
        if (corrupt) c = c ^ 7'h11;
        for (int i = 6; i >= 0; i--) q.push_back(c[i]);
        q.push_back(1'b1);
        for (int i = 0; i < 56; i++) drv_q.push_back(1'b1);
        foreach (q[i]) drv_q.push_back(q[i]);
    endtask

    task automatic push_long(input logic [127:0] body);
        for (int i = 0; i < 56; i++) drv_q.push_back(1'b1);
        drv_q.push_back(1'b0); drv_q.push_back(1'b0);
        for (int i = 0; i < 6; i++) drv_q.push_back(1'b1);
        for (int i = 127; i >= 0; i--) drv_q.push_back(body[i]);
    endtask

    function automatic logic [47:0] cap48();
        logic [47:0] v = '0;
        for (int i = 0; i < cap.size() && i < 48; i++) v[47-i] = cap[i];
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !cmd_oe && cmd_out, "R1 idle outputs", {busy, cmd_oe, cmd_out}, 3'b001);
        chk(status == 0, "R1 status", status, 0);
        chk({resp0, resp1, resp2, resp3} == '0, "R1 resp", resp0, 0);
        rst_n = 1;
        @(negedge clk);

        // R2/R5/R10: index 0, zero argument, no response
        wr_arg(32'h0);
        cap.delete();
        wr_cmd(10'h200);
        while (!status[0]) @(negedge clk);
        chk(cap.size() == 48, "R2 frame length", cap.size(), 48);
        chk(cap48() == 48'h400000000095, "R2 frame idx0", cap48(), 48'h400000000095);
        chk(status == 4'b0001, "R5 sent flag", status, 4'b0001);
        begin
            int n = 0;
            while (busy) begin n++; @(negedge clk); end
            chk(n == 8, "R10 gap length", n, 8);
        end
        wr_clr(4'hF);
        chk(status == 0, "R11 clear all", status, 0);

        // R2/R3: index 8, argument 0x1AA; enabled write mid-frame is ignored
        wr_arg(32'h0000_01AA);
        cap.delete();
        wr_cmd(10'h208);
        repeat (5) @(negedge clk);
        wr_cmd(10'h205);
        wait_idle();
        chk(cap48() == 48'h48000001AA87, "R3 frame unchanged by busy write", cap48(), 48'h48000001AA87);
        chk(status == 4'b0001, "R3 single completion", status, 4'b0001);
        wr_clr(4'hF);

        // R7: short response with good CRC
        wr_arg(32'h1234_5678);
        push_short(6'd17, 32'h0000_0900, 0);
        wr_cmd(10'h251);
        wait_idle();
        chk(status == 4'b0010, "R7 good crc", status, 4'b0010);
        chk(resp0 == 32'h0000_0900, "R7 resp0", resp0, 32'h0000_0900);
        chk(resp1 == 0, "R7 resp1 zero", resp1, 0);
        wr_clr(4'hF);

        // R7: short response with bad CRC
        push_short(6'd13, 32'hDEAD_BEEF, 1);
        wr_cmd(10'h24D);
        wait_idle();
        chk(status == 4'b0100, "R7 bad crc", status, 4'b0100);
        chk(resp0 == 32'hDEAD_BEEF, "R7 resp0 on crc error", resp0, 32'hDEAD_BEEF);
        wr_clr(4'hF);

        // R8: bad CRC with checking off
        push_short(6'd41, 32'h80FF_0001, 1);
        wr_cmd(10'h369);
        wait_idle();
        chk(status == 4'b0010, "R8 crc ignored", status, 4'b0010);
        wr_clr(4'hF);

        // R9: long response
        push_long(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211);
        wr_cmd(10'h2C2);
        wait_idle();
        chk(status == 4'b0010, "R9 long ok", status, 4'b0010);
        chk(resp0 == 32'h0123_4567 && resp3 == 32'h7654_3211, "R9 word order",
            {resp0, resp3}, {32'h0123_4567, 32'h7654_3211});
        chk(resp1 == 32'h89AB_CDEF && resp2 == 32'hFEDC_BA98, "R9 middle words",
            {resp1, resp2}, {32'h89AB_CDEF, 32'hFEDC_BA98});

        // R6: silent line leads to a timeout; R11 partial clear keeps the other flag
        wr_cmd(10'h243);
        wait_idle();
        chk(status == 4'b1010, "R6 timeout flag", status, 4'b1010);
        wr_clr(4'b1000);
        chk(status == 4'b0010, "R11 partial clear", status, 4'b0010);
        wr_clr(4'hF);

        // R4: abort in the middle of a frame
        wr_cmd(10'h203);
        repeat (10) @(negedge clk);
        wr_cmd(10'h000);
        chk(!busy && !cmd_oe, "R4 abort to idle", {busy, cmd_oe}, 2'b00);
        repeat (60) @(negedge clk);
        chk(status == 0, "R4 no flag after abort", status, 0);

        // R3: engine starts again after the abort
        cap.delete();
        wr_arg(32'h0);
        wr_cmd(10'h200);
        wait_idle();
        chk(cap48() == 48'h400000000095, "R3 restart after abort", cap48(), 48'h400000000095);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule